// File: doc/BRIEF.md
# Synchronous Late-Write Burst SRAM

This block models a synchronous static RAM whose bus never needs a turnaround gap. Every command (address, read/write select, byte write enables, advance and the three chip selects) is sampled on the rising clock edge. Write data follows its address by a fixed number of cycles, so a write can sit right after a read on the bus without an idle cycle. The 36-bit data word is made of four 9-bit byte lanes. The read path is modelled as three ports: `din` for incoming data, `dout` for outgoing data, and `dout_en` as the driver enable.

A static strap, `flow_thru`, chooses between two timings. In registered mode, read data passes through an output register and write data arrives two cycles after its address. In flow-through mode, read data comes straight from the array and write data arrives one cycle after its address. A second static strap, `burst_ilv`, sets the burst sequence used by the advance input. That sequence is either linear or interleaved and stays within an aligned group of four words. Two asynchronous inputs can silence the data drivers at any moment: `oe_n` and `sleep`. While `sleep` is high, the block also accepts no command.

The memory depth is 2^`ADDR_W` words and is kept small so the model stays light in simulation. The straps are meant to change only while reset is asserted.

Top module: `lwb_sram`

## Requirements
- R1: While reset is active, and for as long as no read has been accepted afterwards, `dout_en` is 0. Array contents are not cleared by reset.
- R2: With `flow_thru`=0, a read accepted at edge k drives its word with `dout_en`=1 from just after edge k+1 until edge k+2. A four-beat burst therefore takes 3-1-1-1 cycles, counted from the address cycle.
- R3: With `flow_thru`=1, a read accepted at edge k drives its word with `dout_en`=1 from just after edge k until edge k+1. A burst therefore takes 2-1-1-1 cycles.
- R4: A write accepted at edge k takes its data from `din` at edge k+2 when `flow_thru`=0, and at edge k+1 when `flow_thru`=1. Reads and writes may be issued on consecutive edges with no idle edge between them.
- R5: A read always returns the data of every write accepted before it. This includes, in registered mode, a write accepted on the edge just before the read whose data lands on the same edge the read is loaded.
- R6: With `burst_ilv`=0, an edge with `adv`=1 during an active burst accesses the base address with its two low bits replaced by (base low bits + beat) mod 4. The beat counts 1, 2, 3, 0, … and the upper bits stay unchanged.
- R7: With `burst_ilv`=1, the continuation beat instead uses the base low bits XOR the beat number.
- R8: Only byte lanes whose `byte_wr` bit is 1 are written. Bit i controls lane i, which is `din[9i+8:9i]`. The enables are sampled on every write beat, including burst continuations.
- R9: A new command is accepted only when `adv`=0, `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Any other select pattern with `adv`=0 is a deselect. A deselect changes no word, gives no `dout_en`, and ends any burst.
- R10: `oe_n`=1 forces `dout_en` to 0 at once, without waiting for an edge, and does not disturb operations in flight.
- R11: While `sleep`=1, `dout_en` is 0 at once, no command or burst beat is accepted, and any active burst ends.
- R12: `adv`=1 with no active burst is a no-operation. A burst continuation keeps the read/write sense of its starting command, whatever `wr` shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flow_thru | input | 1 | Static: 1 selects flow-through read and single late write, 0 selects registered read and double late write |
| burst_ilv | input | 1 | Static: 1 selects interleaved burst order, 0 selects linear order |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 continues the current burst, 0 starts a new command or deselects |
| wr | input | 1 | 1 write, 0 read, sampled for new commands only |
| byte_wr | input | NBYTES (4) | Per-lane write enables, active high |
| addr | input | ADDR_W (8) | Word address |
| din | input | NBYTES*BYTE_W (36) | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down request, active high |
| dout | output | NBYTES*BYTE_W (36) | Read data |
| dout_en | output | 1 | Data bus driver enable |

## Verification
In registered mode, two things can land on the same clock edge. A late write commits its data to the array, and a read of the same word, issued on the very next edge, loads the output register. The forwarding path has to resolve that collision, including the case where only some byte lanes are enabled. The bench provokes it with directed write-then-read pairs, one of them a partial-lane write, and with random traffic that aims half of its addresses at a 32-word window so that collisions recur. Each returned word is compared with a bench memory that applies writes in issue order, so any read that lost a lane of the colliding write shows up as a data mismatch on `dout`.

// File: rtl/lwb_pkg.sv
package lwb_pkg;

  localparam int BEAT_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } lwb_op_e;

  // Low address bits of a burst beat: linear adds the beat, interleaved XORs it.
  function automatic logic [BEAT_W-1:0] beat_lo(input logic [BEAT_W-1:0] start,
                                                input logic [BEAT_W-1:0] beat,
                                                input logic              ilv);
    if (ilv) beat_lo = start ^ beat;
    else     beat_lo = start + beat;
  endfunction

endpackage

// File: rtl/lwb_rst_sync.sv
module lwb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/lwb_burst_ctrl.sv
module lwb_burst_ctrl
  import lwb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_ilv,
  input  logic              sleep,
  input  logic              adv,
  input  logic              wr,
  input  logic              sel_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBYTES-1:0] byte_wr,
  output lwb_op_e           cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [NBYTES-1:0] cmd_be
);
  logic              act_q, act_d;
  logic              we_q, we_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              st_en;

  // Next state and the command of this edge.
  always_comb begin
    act_d    = act_q;
    we_d     = we_q;
    base_d   = base_q;
    beat_d   = beat_q;
    cmd_op   = OP_IDLE;
    cmd_addr = addr;
    cmd_be   = byte_wr;
    if (sleep) begin
      act_d = 1'b0;
    end else if (adv) begin
      if (act_q) begin
        beat_d   = beat_q + 2'd1;
        cmd_addr = {base_q[ADDR_W-1:BEAT_W], beat_lo(base_q[BEAT_W-1:0], beat_d, burst_ilv)};
        cmd_op   = we_q ? OP_WRITE : OP_READ;
      end
    end else if (sel_ok) begin
      act_d  = 1'b1;
      we_d   = wr;
      base_d = addr;
      beat_d = '0;
      cmd_op = wr ? OP_WRITE : OP_READ;
    end else begin
      act_d = 1'b0;
    end
  end

  // Hold the state when an advance arrives with no burst open.
  assign st_en = sleep || !adv || act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      we_q   <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
    end else if (st_en) begin
      act_q  <= act_d;
      we_q   <= we_d;
      base_q <= base_d;
      beat_q <= beat_d;
    end
  end
endmodule

// File: rtl/lwb_byte_array.sv
module lwb_byte_array #(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [NBYTES-1:0]        wbe,
  input  logic [NBYTES*BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]        raddr,
  output logic [NBYTES*BYTE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];
    logic              lane_we;

    assign lane_we = we && wbe[g];

    always_ff @(posedge clk) begin
      if (lane_we) lane_mem[waddr] <= wdata[g*BYTE_W +: BYTE_W];
    end

    assign rdata[g*BYTE_W +: BYTE_W] = lane_mem[raddr];
  end
endmodule

// File: rtl/lwb_late_port.sv
module lwb_late_port
  import lwb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flow_thru,
  input  lwb_op_e                  cmd_op,
  input  logic [ADDR_W-1:0]        cmd_addr,
  input  logic [NBYTES-1:0]        cmd_be,
  input  logic [NBYTES*BYTE_W-1:0] din,
  input  logic [NBYTES*BYTE_W-1:0] mem_rdata,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_waddr,
  output logic [NBYTES-1:0]        mem_wbe,
  output logic [NBYTES*BYTE_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0]        mem_raddr,
  output logic [NBYTES*BYTE_W-1:0] rd_data,
  output logic                     rd_valid
);
  localparam int DATA_W = NBYTES * BYTE_W;

  lwb_op_e             s1_op_q, s2_op_q;
  logic [ADDR_W-1:0]   s1_addr_q, s2_addr_q;
  logic [NBYTES-1:0]   s1_be_q, s2_be_q;
  logic [DATA_W-1:0]   out_q, out_d;
  logic                out_vld_q, out_vld_d;
  logic                ld_out;
  logic                fwd_hit;
  logic [DATA_W-1:0]   fwd_data;

  // Late-write commit: one stage back in flow-through, two in registered mode.
  always_comb begin
    if (flow_thru) begin
      mem_we    = (s1_op_q == OP_WRITE);
      mem_waddr = s1_addr_q;
      mem_wbe   = s1_be_q;
    end else begin
      mem_we    = (s2_op_q == OP_WRITE);
      mem_waddr = s2_addr_q;
      mem_wbe   = s2_be_q;
    end
  end
  assign mem_wdata = din;
  assign mem_raddr = s1_addr_q;

  // Registered mode: the write one stage ahead commits on the same edge the
  // read is loaded, so its enabled lanes are taken from the bus.
  assign fwd_hit = !flow_thru && (s2_op_q == OP_WRITE) && (s2_addr_q == s1_addr_q);

  for (genvar g = 0; g < NBYTES; g++) begin : g_fwd
    assign fwd_data[g*BYTE_W +: BYTE_W] = (fwd_hit && s2_be_q[g]) ?
                                          din[g*BYTE_W +: BYTE_W] :
                                          mem_rdata[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    ld_out    = !flow_thru && (s1_op_q == OP_READ);
    out_d     = fwd_data;
    out_vld_d = ld_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op_q   <= OP_IDLE;
      s1_addr_q <= '0;
      s1_be_q   <= '0;
      s2_op_q   <= OP_IDLE;
      s2_addr_q <= '0;
      s2_be_q   <= '0;
      out_vld_q <= 1'b0;
    end else begin
      s1_op_q   <= cmd_op;
      s1_addr_q <= cmd_addr;
      s1_be_q   <= cmd_be;
      s2_op_q   <= s1_op_q;
      s2_addr_q <= s1_addr_q;
      s2_be_q   <= s1_be_q;
      out_vld_q <= out_vld_d;
    end
  end

  // Output data register carries no reset; it is qualified by out_vld_q.
  always_ff @(posedge clk) begin
    if (ld_out) out_q <= out_d;
  end

  assign rd_data  = flow_thru ? mem_rdata : out_q;
  assign rd_valid = flow_thru ? (s1_op_q == OP_READ) : out_vld_q;
endmodule

// File: rtl/lwb_sram.sv
module lwb_sram
  import lwb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flow_thru,
  input  logic                     burst_ilv,
  input  logic                     cs1_n,
  input  logic                     cs2,
  input  logic                     cs3_n,
  input  logic                     adv,
  input  logic                     wr,
  input  logic [NBYTES-1:0]        byte_wr,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NBYTES*BYTE_W-1:0] din,
  input  logic                     oe_n,
  input  logic                     sleep,
  output logic [NBYTES*BYTE_W-1:0] dout,
  output logic                     dout_en
);
  localparam int DATA_W = NBYTES * BYTE_W;

  logic              rst_q_n;
  logic              sel_ok;
  lwb_op_e           cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [NBYTES-1:0] cmd_be;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [NBYTES-1:0] mem_wbe;
  logic [DATA_W-1:0] mem_wdata;
  logic [ADDR_W-1:0] mem_raddr;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] rd_data;
  logic              rd_valid;

  assign sel_ok = !cs1_n && cs2 && !cs3_n;

  lwb_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  lwb_burst_ctrl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .burst_ilv (burst_ilv),
    .sleep     (sleep),
    .adv       (adv),
    .wr        (wr),
    .sel_ok    (sel_ok),
    .addr      (addr),
    .byte_wr   (byte_wr),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_be    (cmd_be)
  );

  lwb_late_port #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .flow_thru (flow_thru),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_be    (cmd_be),
    .din       (din),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wbe   (mem_wbe),
    .mem_wdata (mem_wdata),
    .mem_raddr (mem_raddr),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  lwb_byte_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wbe   (mem_wbe),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  // Asynchronous gating of the driver enable.
  assign dout    = rd_data;
  assign dout_en = rd_valid && !oe_n && !sleep;
endmodule

// File: rtl/lwb_sram_chk.sv
module lwb_sram_chk (
  input logic clk,
  input logic rst_q_n,
  input logic flow_thru,
  input logic adv,
  input logic wr,
  input logic cs1_n,
  input logic cs2,
  input logic cs3_n,
  input logic sleep,
  input logic oe_n,
  input logic dout_en
);
  logic new_cmd, rd_new, wr_new, desel;

  assign new_cmd = !adv && !cs1_n && cs2 && !cs3_n && !sleep;
  assign rd_new  = new_cmd && !wr;
  assign wr_new  = new_cmd && wr;
  assign desel   = !adv && !(!cs1_n && cs2 && !cs3_n) && !sleep;

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_q_n |-> !dout_en);

  p_pipe_read_r2: assert property (@(posedge clk) disable iff (!rst_q_n || flow_thru)
    rd_new |=> ##1 (oe_n || sleep || dout_en));

  p_flow_read_r3: assert property (@(posedge clk) disable iff (!rst_q_n || !flow_thru)
    rd_new |=> (oe_n || sleep || dout_en));

  p_flow_write_r4: assert property (@(posedge clk) disable iff (!rst_q_n || !flow_thru)
    wr_new |=> !dout_en);

  p_desel_flow_r9: assert property (@(posedge clk) disable iff (!rst_q_n || !flow_thru)
    desel |=> !dout_en);

  p_desel_pipe_r9: assert property (@(posedge clk) disable iff (!rst_q_n || flow_thru)
    desel |=> ##1 !dout_en);

  p_oe_quiet_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    oe_n |-> !dout_en);

  p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    sleep |-> !dout_en);
endmodule

bind lwb_sram lwb_sram_chk u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .flow_thru (flow_thru),
  .adv       (adv),
  .wr        (wr),
  .cs1_n     (cs1_n),
  .cs2       (cs2),
  .cs3_n     (cs3_n),
  .sleep     (sleep),
  .oe_n      (oe_n),
  .dout_en   (dout_en)
);

// File: tb/lwb_sram_bench.sv
`timescale 1ns/1ps
module lwb_sram_bench;
  localparam int AW = 8;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n, flow_thru, burst_ilv;
  logic          cs1_n, cs2, cs3_n, adv, wr, oe_n, sleep;
  logic [NB-1:0] byte_wr;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic          dout_en;

  lwb_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW)) u_lwb_sram (
    .clk(clk), .rst_n(rst_n), .flow_thru(flow_thru), .burst_ilv(burst_ilv),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .adv(adv), .wr(wr),
    .byte_wr(byte_wr), .addr(addr), .din(din), .oe_n(oe_n), .sleep(sleep),
    .dout(dout), .dout_en(dout_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Bench model state.
  logic [DW-1:0] mdl [DEPTH];
  bit            b_act, b_we;
  logic [AW-1:0] b_base;
  logic [1:0]    b_beat;
  bit            ev [8];
  logic [DW-1:0] ed [8];
  bit            dv [8];
  logic [DW-1:0] dd [8];
  int            ecnt;
  string         cur_tag;
  int            n_run, n_fail;

  function automatic logic [DW-1:0] rnd_word();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    return r[DW-1:0];
  endfunction

  function automatic logic [AW-1:0] bseq(logic [AW-1:0] base, logic [1:0] k, bit il);
    logic [1:0] lo;
    lo = il ? (base[1:0] ^ k) : (base[1:0] + k);
    return {base[AW-1:2], lo};
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old_w, logic [DW-1:0] new_w,
                                          logic [NB-1:0] be);
    logic [DW-1:0] r;
    r = old_w;
    for (int i = 0; i < NB; i++) if (be[i]) r[i*BW +: BW] = new_w[i*BW +: BW];
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // One clock: check the current window, then drive the command for the next edge.
  task automatic cyc(bit a_adv, bit a_wr, bit a_sel, logic [NB-1:0] a_be,
                     logic [AW-1:0] a_addr, bit a_oe_n, bit a_sleep);
    int w, e, lat;
    bit is_rd, is_wr;
    logic [AW-1:0] ea;
    logic [DW-1:0] wd;
    logic [2:0] cs;
    @(negedge clk);
    w = ecnt % 8;
    if (oe_n || sleep) begin
      chk(dout_en === 1'b0, oe_n ? "R10" : "R11", {35'd0, dout_en}, '0);
    end else begin
      chk(dout_en === ev[w], cur_tag, {35'd0, dout_en}, {35'd0, ev[w]});
      if (ev[w] && dout_en) chk(dout === ed[w], cur_tag, dout, ed[w]);
    end
    ev[w] = 1'b0;
    e   = ecnt + 1;
    lat = flow_thru ? 1 : 2;
    din = dv[e % 8] ? dd[e % 8] : rnd_word();
    dv[e % 8] = 1'b0;
    if (a_sel) cs = 3'b010;
    else begin
      cs = 3'($urandom());
      while (cs == 3'b010) cs = 3'($urandom());
    end
    {cs1_n, cs2, cs3_n} = cs;
    adv = a_adv; wr = a_wr; byte_wr = a_be; addr = a_addr;
    oe_n = a_oe_n; sleep = a_sleep;
    is_rd = 1'b0; is_wr = 1'b0; ea = a_addr;
    if (a_sleep) b_act = 1'b0;
    else if (a_adv) begin
      if (b_act) begin
        b_beat = b_beat + 2'd1;
        ea = bseq(b_base, b_beat, burst_ilv);
        is_wr = b_we; is_rd = !b_we;
      end
    end else if (a_sel) begin
      b_act = 1'b1; b_we = a_wr; b_base = a_addr; b_beat = 2'd0;
      is_wr = a_wr; is_rd = !a_wr;
    end else b_act = 1'b0;
    if (is_wr) begin
      wd = rnd_word();
      dd[(e + lat) % 8] = wd;
      dv[(e + lat) % 8] = 1'b1;
      mdl[ea] = merge(mdl[ea], wd, a_be);
    end
    if (is_rd) begin
      ev[(e + lat - 1) % 8] = 1'b1;
      ed[(e + lat - 1) % 8] = mdl[ea];
    end
    @(posedge clk);
    ecnt++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, '1, '0, 1'b0, 1'b0);
  endtask
  task automatic wr1(logic [AW-1:0] a, logic [NB-1:0] be);
    cyc(1'b0, 1'b1, 1'b1, be, a, 1'b0, 1'b0);
  endtask
  task automatic rd1(logic [AW-1:0] a);
    cyc(1'b0, 1'b0, 1'b1, '1, a, 1'b0, 1'b0);
  endtask
  task automatic nxt(bit w_sense);
    cyc(1'b1, w_sense, 1'b1, '1, '0, 1'b0, 1'b0);
  endtask

  task automatic do_reset(bit fl, bit il);
    idle(4);
    @(negedge clk);
    rst_n = 1'b0; adv = 1'b0; cs1_n = 1'b1; cs2 = 1'b0; cs3_n = 1'b1;
    oe_n = 1'b0; sleep = 1'b0;
    flow_thru = fl; burst_ilv = il;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(dout_en === 1'b0, "R1", {35'd0, dout_en}, '0);
    end
    rst_n = 1'b1;
    b_act = 1'b0;
    for (int i = 0; i < 8; i++) begin ev[i] = 1'b0; dv[i] = 1'b0; end
    cur_tag = "R1";
    idle(4);
  endtask

  task automatic directed();
    cur_tag = "R4";
    wr1(8'd10, '1); wr1(8'd11, '1); rd1(8'd10); rd1(8'd11); idle(3);
    cur_tag = "R5";
    wr1(8'd20, '1); rd1(8'd20); wr1(8'd21, '1); rd1(8'd21); rd1(8'd20);
    wr1(8'd20, 4'b0011); rd1(8'd20); idle(3);
    cur_tag = "R8";
    wr1(8'd30, 4'b0101); rd1(8'd30); wr1(8'd30, 4'b1000); idle(1); rd1(8'd30); idle(3);
    cur_tag = burst_ilv ? "R7" : "R6";
    wr1(8'd42, '1); nxt(1'b0); nxt(1'b0); nxt(1'b0);
    rd1(8'd41); nxt(1'b1); nxt(1'b1); nxt(1'b1); nxt(1'b1);
    rd1(8'd42); rd1(8'd43); rd1(8'd40); rd1(8'd41); idle(3);
    cur_tag = "R9";
    cyc(1'b0, 1'b1, 1'b0, '1, 8'd50, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, '1, 8'd50, 1'b0, 1'b0);
    rd1(8'd50); idle(3);
    cur_tag = "R12";
    cyc(1'b1, 1'b1, 1'b1, '1, 8'd51, 1'b0, 1'b0);
    rd1(8'd51); cyc(1'b1, 1'b1, 1'b1, 4'b1111, 8'd0, 1'b0, 1'b0);
    rd1(8'd52); idle(3);
    cur_tag = "R10";
    rd1(8'd60); cyc(1'b0, 1'b0, 1'b1, '1, 8'd61, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, '1, 8'd0, 1'b1, 1'b0); idle(2); rd1(8'd60); idle(3);
    cur_tag = "R11";
    cyc(1'b0, 1'b1, 1'b1, '1, 8'd61, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 1'b1, '1, 8'd61, 1'b0, 1'b1);
    idle(1); rd1(8'd61);
    rd1(8'd64); cyc(1'b1, 1'b0, 1'b1, '1, 8'd0, 1'b0, 1'b1);
    cyc(1'b1, 1'b0, 1'b1, '1, 8'd0, 1'b0, 1'b0); idle(3);
  endtask

  task automatic random_phase(int n);
    cur_tag = flow_thru ? "R3" : "R2";
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a;
      logic [NB-1:0] be;
      a  = ($urandom() % 2 == 0) ? AW'($urandom() % 32) : AW'($urandom());
      be = ($urandom() % 3 == 0) ? '1 : NB'($urandom());
      cyc(($urandom() % 10) < 4, $urandom() % 2 == 1, ($urandom() % 100) < 85,
          be, a, ($urandom() % 100) < 8, ($urandom() % 100) < 4);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    n_run = 0; n_fail = 0; ecnt = 0;
    rst_n = 1'b0; flow_thru = 1'b1; burst_ilv = 1'b0;
    adv = 1'b0; wr = 1'b0; cs1_n = 1'b1; cs2 = 1'b0; cs3_n = 1'b1;
    byte_wr = '0; addr = '0; din = '0; oe_n = 1'b0; sleep = 1'b0;
    b_act = 1'b0; b_we = 1'b0; b_base = '0; b_beat = '0;
    for (int i = 0; i < 8; i++) begin ev[i] = 1'b0; dv[i] = 1'b0; end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(dout_en === 1'b0, "R1", {35'd0, dout_en}, '0);
    end
    rst_n = 1'b1;
    cur_tag = "R1";
    idle(4);
    // Fill the array with linear write bursts.
    cur_tag = "R4";
    for (int i = 0; i < DEPTH / 4; i++) begin
      wr1(AW'(i * 4), '1); nxt(1'b0); nxt(1'b0); nxt(1'b0);
    end
    idle(3);
    directed(); random_phase(2000);
    do_reset(1'b1, 1'b1); directed(); random_phase(2000);
    do_reset(1'b0, 1'b0); directed(); random_phase(2000);
    do_reset(1'b0, 1'b1); directed(); random_phase(2000);
    idle(4);
    summary();
    $finish;
  end
endmodule